// File: doc/BRIEF.md
# Decode Operand Bypass Selector

This block produces the two operand values that the decode stage hands on to execute. In a five-stage pipeline, a register that decode reads may still be waiting for a write from an older instruction further down the pipe. The register file then returns a stale value. For each operand, the block compares the source register identifier against five in-flight destinations and picks the youngest matching result. It falls back to the register-file read only when nothing matches.

The five candidates keep arithmetic results apart from loaded data at every level:

- the arithmetic result being computed in execute;
- the word that the memory stage is reading in this cycle;
- the arithmetic result latched in the memory pipeline register;
- the loaded word latched in the writeback pipeline register;
- the arithmetic result latched in the writeback pipeline register.

The second candidate is the path that completes a load-use sequence once the pipeline has inserted a one-cycle stall. The block is purely combinational. Both operands use identical selection logic and are evaluated independently.

Top module: `fwd_unit`

## Requirements
- R1: When no candidate destination equals an operand's source identifier, that operand equals its register-file read value.
- R2: A match on the execute arithmetic destination (`ex_alu_dst_i`) selects `ex_alu_val_i`. This holds whatever the other candidates or the register-file value hold.
- R3: A match on the memory-stage load destination selects `mem_ld_val_i` over the memory-register arithmetic value, both writeback values and the register file, provided execute does not also match.
- R4: A match on the memory-register arithmetic destination selects `mreg_alu_val_i` over both writeback values and the register file, provided neither younger candidate matches.
- R5: A match on the writeback load destination selects `wreg_ld_val_i` over the writeback arithmetic value and the register file, provided no younger candidate matches.
- R6: A match on the writeback arithmetic destination selects `wreg_alu_val_i` over the register file, provided no other candidate matches.
- R7: Identifier 4'hF means "no register". A source or destination equal to 4'hF never matches, even when both sides are 4'hF. Identifier 4'h0 is an ordinary register.
- R8: Operand A depends only on `src_a_i` and `rf_a_i`, and operand B depends only on `src_b_i` and `rf_b_i`, each combined with the shared candidates. Equal sources and equal register-file values give equal operands.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_i | input | 4 | Operand A source register identifier |
| src_b_i | input | 4 | Operand B source register identifier |
| rf_a_i | input | 32 | Register-file read for operand A |
| rf_b_i | input | 32 | Register-file read for operand B |
| ex_alu_dst_i | input | 4 | Destination of the arithmetic result in execute |
| ex_alu_val_i | input | 32 | Arithmetic result in execute |
| mem_ld_dst_i | input | 4 | Destination of the word being loaded in the memory stage |
| mem_ld_val_i | input | 32 | Word being loaded in the memory stage |
| mreg_alu_dst_i | input | 4 | Arithmetic destination held in the memory register |
| mreg_alu_val_i | input | 32 | Arithmetic result held in the memory register |
| wreg_ld_dst_i | input | 4 | Load destination held in the writeback register |
| wreg_ld_val_i | input | 32 | Loaded word held in the writeback register |
| wreg_alu_dst_i | input | 4 | Arithmetic destination held in the writeback register |
| wreg_alu_val_i | input | 32 | Arithmetic result held in the writeback register |
| op_a_o | output | 32 | Final operand A |
| op_b_o | output | 32 | Final operand B |

## Verification
The block holds no state, so a fault in its match or priority logic shows at the operand ports in the same evaluation as the inputs that expose it.

A reversed priority only shows when two candidates name the same register. The stimulus therefore stacks matching destinations at each priority level.

A broken "no register" guard only shows when identifier 4'hF appears on both sides of a comparison. A crossed operand path only shows when the two sources differ, so the stimulus includes such cases.

// File: rtl/fwd_pkg.sv
package fwd_pkg;
  localparam int NUM_SRC = 5;
  // index order is priority order, youngest first
  typedef enum logic [2:0] {
    SRC_EX_ALU   = 3'd0,
    SRC_MEM_LD   = 3'd1,
    SRC_MREG_ALU = 3'd2,
    SRC_WREG_LD  = 3'd3,
    SRC_WREG_ALU = 3'd4
  } fwd_src_e;
endpackage

// File: rtl/fwd_match.sv
module fwd_match #(
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 5
) (
  input  logic [REG_W-1:0]              src_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0] dst_i,
  output logic [NUM_SRC-1:0]            hit_o
);
  localparam logic [REG_W-1:0] NoneId = '1;

  logic src_valid;
  assign src_valid = (src_i != NoneId);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_cmp
    assign hit_o[g] = src_valid && (dst_i[g] == src_i);
  end
endmodule

// File: rtl/fwd_prio_sel.sv
module fwd_prio_sel #(
  parameter int DATA_W  = 32,
  parameter int NUM_SRC = 5
) (
  input  logic [NUM_SRC-1:0]             hit_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] cand_i,
  input  logic [DATA_W-1:0]              rf_i,
  output logic [DATA_W-1:0]              val_o
);
  // lowest index wins: scan oldest to youngest so younger overwrites
  always_comb begin
    val_o = rf_i;
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (hit_i[i]) val_o = cand_i[i];
    end
  end
endmodule

// File: rtl/fwd_operand.sv
module fwd_operand #(
  parameter int DATA_W  = 32,
  parameter int REG_W   = 4,
  parameter int NUM_SRC = 5
) (
  input  logic [REG_W-1:0]               src_i,
  input  logic [DATA_W-1:0]              rf_i,
  input  logic [NUM_SRC-1:0][REG_W-1:0]  dst_i,
  input  logic [NUM_SRC-1:0][DATA_W-1:0] cand_i,
  output logic [DATA_W-1:0]              val_o
);
  logic [NUM_SRC-1:0] hit;

  fwd_match #(.REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_match (
    .src_i (src_i),
    .dst_i (dst_i),
    .hit_o (hit)
  );

  fwd_prio_sel #(.DATA_W(DATA_W), .NUM_SRC(NUM_SRC)) i_sel (
    .hit_i  (hit),
    .cand_i (cand_i),
    .rf_i   (rf_i),
    .val_o  (val_o)
  );
endmodule

// File: rtl/fwd_unit.sv
module fwd_unit
  import fwd_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4
) (
  input  logic [REG_W-1:0]  src_a_i,
  input  logic [REG_W-1:0]  src_b_i,
  input  logic [DATA_W-1:0] rf_a_i,
  input  logic [DATA_W-1:0] rf_b_i,
  input  logic [REG_W-1:0]  ex_alu_dst_i,
  input  logic [DATA_W-1:0] ex_alu_val_i,
  input  logic [REG_W-1:0]  mem_ld_dst_i,
  input  logic [DATA_W-1:0] mem_ld_val_i,
  input  logic [REG_W-1:0]  mreg_alu_dst_i,
  input  logic [DATA_W-1:0] mreg_alu_val_i,
  input  logic [REG_W-1:0]  wreg_ld_dst_i,
  input  logic [DATA_W-1:0] wreg_ld_val_i,
  input  logic [REG_W-1:0]  wreg_alu_dst_i,
  input  logic [DATA_W-1:0] wreg_alu_val_i,
  output logic [DATA_W-1:0] op_a_o,
  output logic [DATA_W-1:0] op_b_o
);
  localparam int NumOps = 2;

  logic [NUM_SRC-1:0][REG_W-1:0]  dst;
  logic [NUM_SRC-1:0][DATA_W-1:0] cand;
  logic [NumOps-1:0][REG_W-1:0]   src;
  logic [NumOps-1:0][DATA_W-1:0]  rf;
  logic [NumOps-1:0][DATA_W-1:0]  op;

  always_comb begin
    dst[SRC_EX_ALU]    = ex_alu_dst_i;
    dst[SRC_MEM_LD]    = mem_ld_dst_i;
    dst[SRC_MREG_ALU]  = mreg_alu_dst_i;
    dst[SRC_WREG_LD]   = wreg_ld_dst_i;
    dst[SRC_WREG_ALU]  = wreg_alu_dst_i;
    cand[SRC_EX_ALU]   = ex_alu_val_i;
    cand[SRC_MEM_LD]   = mem_ld_val_i;
    cand[SRC_MREG_ALU] = mreg_alu_val_i;
    cand[SRC_WREG_LD]  = wreg_ld_val_i;
    cand[SRC_WREG_ALU] = wreg_alu_val_i;
  end

  assign src[0] = src_a_i;
  assign src[1] = src_b_i;
  assign rf[0]  = rf_a_i;
  assign rf[1]  = rf_b_i;

  for (genvar g = 0; g < NumOps; g++) begin : g_op
    fwd_operand #(.DATA_W(DATA_W), .REG_W(REG_W), .NUM_SRC(NUM_SRC)) i_operand (
      .src_i  (src[g]),
      .rf_i   (rf[g]),
      .dst_i  (dst),
      .cand_i (cand),
      .val_o  (op[g])
    );
  end

  assign op_a_o = op[0];
  assign op_b_o = op[1];
endmodule

// File: rtl/fwd_unit_chk.sv
module fwd_unit_chk #(
  parameter int DATA_W = 32,
  parameter int REG_W  = 4
) (
  input logic [REG_W-1:0]  src_a_i,
  input logic [REG_W-1:0]  src_b_i,
  input logic [DATA_W-1:0] rf_a_i,
  input logic [DATA_W-1:0] rf_b_i,
  input logic [REG_W-1:0]  ex_alu_dst_i,
  input logic [DATA_W-1:0] ex_alu_val_i,
  input logic [REG_W-1:0]  mem_ld_dst_i,
  input logic [DATA_W-1:0] mem_ld_val_i,
  input logic [REG_W-1:0]  mreg_alu_dst_i,
  input logic [REG_W-1:0]  wreg_ld_dst_i,
  input logic [REG_W-1:0]  wreg_alu_dst_i,
  input logic [DATA_W-1:0] op_a_o,
  input logic [DATA_W-1:0] op_b_o
);
  localparam logic [REG_W-1:0] NoneId = '1;

  always_comb begin
    // no-register source reads the file
    if (src_a_i == NoneId)
      assert_none_src_a_R7: assert (op_a_o == rf_a_i);
    if (src_b_i == NoneId)
      assert_none_src_b_R7: assert (op_b_o == rf_b_i);
    // execute match dominates
    if (src_a_i != NoneId && ex_alu_dst_i == src_a_i)
      assert_ex_wins_a_R2: assert (op_a_o == ex_alu_val_i);
    if (src_b_i != NoneId && ex_alu_dst_i == src_b_i)
      assert_ex_wins_b_R2: assert (op_b_o == ex_alu_val_i);
    // memory-stage load beats older ones
    if (src_a_i != NoneId && ex_alu_dst_i != src_a_i && mem_ld_dst_i == src_a_i)
      assert_mem_ld_a_R3: assert (op_a_o == mem_ld_val_i);
    // nothing matches -> register file
    if (ex_alu_dst_i != src_a_i && mem_ld_dst_i != src_a_i && mreg_alu_dst_i != src_a_i &&
        wreg_ld_dst_i != src_a_i && wreg_alu_dst_i != src_a_i)
      assert_no_match_a_R1: assert (op_a_o == rf_a_i);
    // symmetric operand paths
    if (src_a_i == src_b_i && rf_a_i == rf_b_i)
      assert_same_src_R8: assert (op_a_o == op_b_o);
  end
endmodule

bind fwd_unit fwd_unit_chk #(.DATA_W(DATA_W), .REG_W(REG_W)) i_fwd_unit_chk (
  .src_a_i        (src_a_i),
  .src_b_i        (src_b_i),
  .rf_a_i         (rf_a_i),
  .rf_b_i         (rf_b_i),
  .ex_alu_dst_i   (ex_alu_dst_i),
  .ex_alu_val_i   (ex_alu_val_i),
  .mem_ld_dst_i   (mem_ld_dst_i),
  .mem_ld_val_i   (mem_ld_val_i),
  .mreg_alu_dst_i (mreg_alu_dst_i),
  .wreg_ld_dst_i  (wreg_ld_dst_i),
  .wreg_alu_dst_i (wreg_alu_dst_i),
  .op_a_o         (op_a_o),
  .op_b_o         (op_b_o)
);

// File: tb/test_fwd_unit.sv
module test_fwd_unit;
  localparam int CLK_PERIOD = 10;
  localparam int DW = 32;
  localparam int RW = 4;
  localparam int NROWS = 10;

  localparam logic [DW-1:0] V_EX   = 32'hE0E0_0001;
  localparam logic [DW-1:0] V_MLD  = 32'hD1D1_0002;
  localparam logic [DW-1:0] V_MALU = 32'hC2C2_0003;
  localparam logic [DW-1:0] V_WLD  = 32'hB3B3_0004;
  localparam logic [DW-1:0] V_WALU = 32'hA4A4_0005;

  // nibbles: src_a src_b ex mld malu wld walu expA expB
  // expected code: 0 ex,1 mld,2 malu,3 wld,4 walu,5 register file
  localparam logic [NROWS-1:0][35:0] VEC = {
    36'h23FFFFF55,  // R1
    36'h232222205,  // R2
    36'h233222210,  // R3
    36'h441544422,  // R4 R8
    36'h671116734,  // R5 R6
    36'h610006635,  // R5
    36'h991111944,  // R6
    36'hFFFFFFF55,  // R7
    36'hF2FFFF254,  // R7
    36'h000000000   // R7 reg 0 is real
  };

  logic clk = 1'b0;
  logic [RW-1:0] src_a, src_b, ex_d, mld_d, malu_d, wld_d, walu_d;
  logic [DW-1:0] rf_a, rf_b, op_a, op_b;
  int checks = 0;
  int failures = 0;
  bit done = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  fwd_unit i_fwd_unit (
    .src_a_i(src_a), .src_b_i(src_b), .rf_a_i(rf_a), .rf_b_i(rf_b),
    .ex_alu_dst_i(ex_d), .ex_alu_val_i(V_EX),
    .mem_ld_dst_i(mld_d), .mem_ld_val_i(V_MLD),
    .mreg_alu_dst_i(malu_d), .mreg_alu_val_i(V_MALU),
    .wreg_ld_dst_i(wld_d), .wreg_ld_val_i(V_WLD),
    .wreg_alu_dst_i(walu_d), .wreg_alu_val_i(V_WALU),
    .op_a_o(op_a), .op_b_o(op_b)
  );

  function automatic logic [DW-1:0] exp_val(input logic [3:0] code, input logic [DW-1:0] rf);
    case (code)
      4'd0: return V_EX;
      4'd1: return V_MLD;
      4'd2: return V_MALU;
      4'd3: return V_WLD;
      4'd4: return V_WALU;
      default: return rf;
    endcase
  endfunction

  task automatic check(input string req, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [35:0] v);
    @(negedge clk);
    {src_a, src_b, ex_d, mld_d, malu_d, wld_d, walu_d} = v[35:8];
    rf_a = 32'hAAAA_0000 | DW'(v[35:32]);
    rf_b = 32'h5555_0000 | DW'(v[31:28]);
    #(CLK_PERIOD/4);
  endtask

  initial begin
    // idle: every identifier is "no register"
    drive(36'hFFFFFFF55);
    check("R1 idle opA", op_a, rf_a);
    check("R1 idle opB", op_b, rf_b);

    for (int i = NROWS - 1; i >= 0; i--) begin
      drive(VEC[i]);
      check($sformatf("R1-table row %0d opA", NROWS - 1 - i), op_a, exp_val(VEC[i][7:4], rf_a));
      check($sformatf("R1-table row %0d opB", NROWS - 1 - i), op_b, exp_val(VEC[i][3:0], rf_b));
    end

    // R2: forwarded operand ignores a changing register-file value
    drive(36'h232222205);
    rf_a = 32'h1234_5678;
    #(CLK_PERIOD/8);
    check("R2 rf change ignored", op_a, V_EX);

    // R8: operand B tracks its own file value when A forwards
    rf_b = 32'h0BAD_F00D;
    #(CLK_PERIOD/8);
    check("R8 opB independent", op_b, 32'h0BAD_F00D);

    // R7: 0xF destination never matches register 0xE or 0xF source
    drive(36'hEFFFFFF55);
    check("R7 no-reg dst vs 0xE", op_a, rf_a);

    // R3: load value reaches both operands when both read the loaded register
    drive(36'h55F5555FF);
    check("R3 load fwd opA", op_a, V_MLD);
    check("R3 load fwd opB", op_b, V_MLD);

    done = 1'b1;
  end

  initial begin
    for (int c = 0; c < 2000 && !done; c++) @(posedge clk);
    if (!done) begin
      failures++;
      $display("FAIL watchdog R1 actual=timeout expected=done");
    end
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule